// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous memory whose write data trails its address by one clock. An operation is requested at a rising clock edge through an active-low select, an active-low global write enable, and four active-low lane enables. The data for a write is taken at the next rising edge. Accepted writes wait in a two-entry buffer. The oldest entry is moved into the storage array only when a later write frees its slot. A read that targets a buffered location gets the buffered lanes in place of the stale array lanes, so reads always see the latest write.

Read results are loaded into an output register on the falling clock edge. An output enable acts on the output without regard to the clock. A synchronous sleep input stops the block from accepting operations. The data bus appears as separate input and output words plus a drive-enable flag, and the array depth is a parameter.

Top module: `lsram_core`

## Requirements
- R1: At a rising edge, an operation is accepted only when `sel_n`=0 and `sleep_n`=1. It is a write if `we_n`=0 and a read if `we_n`=1. A cycle with `sel_n`=1 neither reads nor writes.
- R2: The data of an accepted write is sampled from `wdata` at the rising edge that follows the write's address edge, whatever that later cycle requests.
- R3: The word is four 9-bit lanes. Lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. `bwe_n[i]`=0 lets a write change lane i. Lanes with `bwe_n[i]`=1 keep their old contents.
- R4: A read accepted at a rising edge loads `rdata` at the falling edge of that same cycle. The value is held until the falling edge of the next accepted read.
- R5: `oe_n`=1 forces `rdata` to zero and `rdata_oe` to 0 at once. `oe_n`=0 sets `rdata_oe` to 1 and shows the output register.
- R6: While `sleep_n`=0, no read or write is accepted. Data owed to a write accepted earlier is still sampled.
- R7: The oldest buffered write is committed to the array only when a new write is accepted. Reads and idle cycles leave both buffer entries unchanged.
- R8: A read returns, per lane, the newer buffered write to its address if one covers that lane. Otherwise it returns the older buffered write if one covers the lane, and otherwise the array contents.
- R9: With `we_n`=1, low lane enables have no effect: the cycle is a read and memory is unchanged.
- R10: Synchronous reset empties the write buffer and clears the output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Synchronous select, active low |
| sleep_n | input | 1 | Synchronous sleep, active low |
| we_n | input | 1 | Global write enable, active low |
| bwe_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address |
| wdata | input | 36 | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data from the falling-edge register |
| rdata_oe | output | 1 | Output drive enable |

## Verification
A fixed vector sequence writes two addresses back to back, so that each read can be traced to a single source. A read of the older entry shows forwarding from the older buffer slot, and a read of the newer entry shows forwarding from the newer slot. Partial-lane writes to already-committed words check that lanes merge correctly with array contents. Two overlapping partial writes held in the buffer at once check that the newer entry wins, lane by lane. Directed cycles then check the following:
- a disabled global enable, a deselect and sleep each leave memory untouched, while data owed to an earlier write is still taken during sleep;
- the output changes at the falling edge and not before;
- the output enable acts without waiting for the clock.

// File: rtl/lsram_pkg.sv
`timescale 1ns/1ps
package lsram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Active-low controls to the operation accepted this edge
    function automatic op_e decode_op(logic sel_n, logic sleep_n, logic we_n);
        if (sel_n || !sleep_n) return OP_NONE;
        return we_n ? OP_READ : OP_WRITE;
    endfunction

    // Overlay the lanes of upd selected by m onto base
    function automatic word_t lane_merge(word_t base, word_t upd, lane_mask_t m);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lsram_array.sv
`timescale 1ns/1ps
module lsram_array
    import lsram_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  lane_mask_t    wr_mask,
    input  word_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    // One storage bank per lane so each lane is written independently
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/lsram_wbuf.sv
`timescale 1ns/1ps
module lsram_wbuf
    import lsram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  lane_mask_t    push_mask,
    input  word_t         wdata,
    output logic          commit_en,
    output logic [AW-1:0] commit_addr,
    output lane_mask_t    commit_mask,
    output word_t         commit_data,
    input  logic [AW-1:0] look_addr,
    input  word_t         base_word,
    output word_t         fwd_word
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        lane_mask_t    mask;
        word_t         data;
    } entry_t;

    entry_t     e_new, e_old;
    logic       fill_pend;
    word_t      new_data_now;
    lane_mask_t hit_old, hit_new;

    // Data owed to the newest write lands on the edge after its push
    assign new_data_now = fill_pend ? wdata : e_new.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_new     <= '0;
            e_old     <= '0;
            fill_pend <= 1'b0;
        end else begin
            fill_pend <= push;
            if (push) begin
                e_old <= '{valid: e_new.valid, addr: e_new.addr,
                           mask: e_new.mask, data: new_data_now};
                e_new <= '{valid: 1'b1, addr: push_addr,
                           mask: push_mask, data: '0};
            end else if (fill_pend) begin
                e_new.data <= wdata;
            end
        end
    end

    // Older entry drains to the array when a new write takes its slot
    assign commit_en   = push && e_old.valid;
    assign commit_addr = e_old.addr;
    assign commit_mask = e_old.mask;
    assign commit_data = e_old.data;

    // Forwarding: array, then older entry, then newer entry on top
    assign hit_old = (e_old.valid && e_old.addr == look_addr) ? e_old.mask : '0;
    assign hit_new = (e_new.valid && !fill_pend && e_new.addr == look_addr)
                     ? e_new.mask : '0;
    assign fwd_word = lane_merge(lane_merge(base_word, e_old.data, hit_old),
                                 e_new.data, hit_new);

    assert_commit_shift_R7: assert property (@(posedge clk) disable iff (rst)
        push |=> (e_old.valid == $past(e_new.valid) && e_old.addr == $past(e_new.addr)));

    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !push |=> ($stable(e_old) && $stable(e_new.addr) && $stable(e_new.mask)));

    assert_fill_owner_R2: assert property (@(posedge clk) disable iff (rst)
        fill_pend |-> e_new.valid);

endmodule

// File: rtl/lsram_core.sv
`timescale 1ns/1ps
module lsram_core
    import lsram_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             sleep_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bwe_n,
    input  logic [AW-1:0]    addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic             oe_n,
    output logic [WORD_W-1:0] rdata,
    output logic             rdata_oe
);

    op_e           op;
    logic          rd_pend;
    logic [AW-1:0] rd_addr_q;
    word_t         dout_q;
    word_t         arr_word;
    word_t         fwd_word;
    logic          commit_en;
    logic [AW-1:0] commit_addr;
    lane_mask_t    commit_mask;
    word_t         commit_data;

    assign op = decode_op(sel_n, sleep_n, we_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_pend <= (op == OP_READ);
            if (op == OP_READ) rd_addr_q <= addr;
        end
    end

    lsram_wbuf #(.AW(AW)) u_wbuf (
        .clk         (clk),
        .rst         (rst),
        .push        (op == OP_WRITE),
        .push_addr   (addr),
        .push_mask   (~bwe_n),
        .wdata       (wdata),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_mask (commit_mask),
        .commit_data (commit_data),
        .look_addr   (rd_addr_q),
        .base_word   (arr_word),
        .fwd_word    (fwd_word)
    );

    lsram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (commit_addr),
        .wr_mask (commit_mask),
        .wr_data (commit_data),
        .rd_addr (rd_addr_q),
        .rd_data (arr_word)
    );

    // Output register loads on the falling edge of the read cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            dout_q <= '0;
        end else if (rd_pend) begin
            dout_q <= fwd_word;
        end
    end

    assign rdata_oe = ~oe_n;
    assign rdata    = oe_n ? '0 : dout_q;

    assert_sleep_block_R6: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> !rd_pend);

    assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !rd_pend);

    assert_rdaddr_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sleep_n && we_n) |=> (rd_pend && rd_addr_q == $past(addr)));

    assert_out_hold_R4: assert property (@(negedge clk) disable iff (rst)
        !rd_pend |=> $stable(dout_q));

endmodule

// File: tb/test_lsram_core.sv
`timescale 1ns/1ps
module test_lsram_core;

    typedef struct packed {
        logic        sel_n;
        logic        we_n;
        logic [3:0]  bwe_n;
        logic [3:0]  addr;
        logic [35:0] wdata;
        logic        chk;
        logic [35:0] exp;
    } vec_t;

    localparam logic [35:0] D3  = {9'h111, 9'h112, 9'h113, 9'h114};
    localparam logic [35:0] D5  = {9'h151, 9'h152, 9'h153, 9'h154};
    localparam logic [35:0] P3  = {9'h1D0, 9'h1C0, 9'h1B0, 9'h1A0};
    localparam logic [35:0] E3  = {9'h111, 9'h1C0, 9'h113, 9'h1A0};
    localparam logic [35:0] Q5  = {9'h1F0, 9'h1F1, 9'h1F2, 9'h1F3};
    localparam logic [35:0] E8  = {9'h1F0, 9'h152, 9'h153, 9'h154};
    localparam logic [35:0] R5  = {9'h0AA, 9'h0AB, 9'h0AC, 9'h0AD};
    localparam logic [35:0] E10 = {9'h1F0, 9'h152, 9'h0AC, 9'h154};
    localparam logic [35:0] S5  = {9'h0E1, 9'h0E2, 9'h0E3, 9'h0E4};
    localparam logic [35:0] E13 = {9'h0E1, 9'h152, 9'h0E3, 9'h154};
    localparam logic [35:0] D7  = {9'h171, 9'h172, 9'h173, 9'h174};
    localparam logic [35:0] JNK = 36'hF_FFFF_FFFF;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'b0000, 4'd3, 36'h0, 1'b0, 36'h0}, // R1 write addr 3
        '{1'b0, 1'b0, 4'b0000, 4'd5, D3,    1'b0, 36'h0}, // R2 data for addr 3
        '{1'b0, 1'b1, 4'b1111, 4'd3, D5,    1'b1, D3},    // R8 older slot forwarded
        '{1'b0, 1'b1, 4'b1111, 4'd5, 36'h0, 1'b1, D5},    // R8 newer slot forwarded
        '{1'b0, 1'b0, 4'b1010, 4'd3, 36'h0, 1'b0, 36'h0}, // R3 lanes 0,2; R7 commit
        '{1'b0, 1'b1, 4'b1111, 4'd3, P3,    1'b1, E3},    // R3 partial over array
        '{1'b0, 1'b0, 4'b0111, 4'd5, 36'h0, 1'b0, 36'h0}, // R3 lane 3
        '{1'b1, 1'b1, 4'b1111, 4'd0, Q5,    1'b0, 36'h0}, // R2 data taken in deselect
        '{1'b0, 1'b1, 4'b1111, 4'd5, 36'h0, 1'b1, E8},    // R2 R8
        '{1'b0, 1'b0, 4'b1101, 4'd5, 36'h0, 1'b0, 36'h0}, // R7 commit addr 3 partial
        '{1'b0, 1'b1, 4'b1111, 4'd5, R5,    1'b1, E10},   // R8 both slots plus array
        '{1'b0, 1'b1, 4'b1111, 4'd3, 36'h0, 1'b1, E3},    // R7 committed word
        '{1'b0, 1'b0, 4'b0101, 4'd5, 36'h0, 1'b0, 36'h0}, // R3 lanes 1,3
        '{1'b0, 1'b1, 4'b1111, 4'd5, S5,    1'b1, E13},   // R8 newer wins
        '{1'b0, 1'b1, 4'b0000, 4'd3, 36'h0, 1'b1, E3},    // R9 global enable off
        '{1'b0, 1'b1, 4'b1111, 4'd5, JNK,   1'b1, E13},   // R9 nothing written
        '{1'b1, 1'b0, 4'b0000, 4'd5, 36'h0, 1'b0, 36'h0}, // R1 deselected write
        '{1'b0, 1'b1, 4'b1111, 4'd5, JNK,   1'b1, E13}    // R1 memory untouched
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, sleep_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  bwe_n = 4'hF;
    logic [3:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsram_core #(.DEPTH(16)) i_lsram_core (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sleep_n(sleep_n), .we_n(we_n),
        .bwe_n(bwe_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic [3:0] b,
                         input logic [3:0] a, input logic [35:0] d, input logic slp);
        sel_n = s; we_n = w; bwe_n = b; addr = a; wdata = d; sleep_n = slp;
    endtask

    // Advance to 1 ns after the following falling edge
    task automatic step();
        @(posedge clk);
        #3;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();
        check("R10 reset rdata", rdata, 36'h0);
        check("R10 reset rdata_oe", {35'h0, rdata_oe}, 36'h1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sel_n, VEC[i].we_n, VEC[i].bwe_n, VEC[i].addr, VEC[i].wdata, 1'b1);
            step();
            if (VEC[i].chk) check($sformatf("R8 vector %0d", i), rdata, VEC[i].exp);
        end

        // R4: output changes at the falling edge, not at the rising edge
        drive(1'b0, 1'b1, 4'hF, 4'd3, 36'h0, 1'b1);
        @(posedge clk);
        #1 check("R4 before falling edge", rdata, E13);
        #2 check("R4 after falling edge", rdata, E3);
        drive(1'b1, 1'b1, 4'hF, 4'd0, 36'h0, 1'b1);

        // R5: output enable acts between clock edges
        #0.5 oe_n = 1'b1;
        #0.2 check("R5 disabled rdata", rdata, 36'h0);
        check("R5 disabled rdata_oe", {35'h0, rdata_oe}, 36'h0);
        #0.2 oe_n = 1'b0;
        #0.2 check("R5 enabled rdata", rdata, E3);
        check("R5 enabled rdata_oe", {35'h0, rdata_oe}, 36'h1);
        step();

        // R6: sleeping read does not update the output
        drive(1'b0, 1'b1, 4'hF, 4'd5, 36'h0, 1'b0);
        step();
        check("R6 read ignored in sleep", rdata, E3);
        // R6: write to 7, then a sleeping write to 3 that still carries 7's data
        drive(1'b0, 1'b0, 4'h0, 4'd7, 36'h0, 1'b1);
        step();
        drive(1'b0, 1'b0, 4'h0, 4'd3, D7, 1'b0);
        step();
        drive(1'b0, 1'b1, 4'hF, 4'd7, JNK, 1'b1);
        step();
        check("R6 data taken during sleep", rdata, D7);
        drive(1'b0, 1'b1, 4'hF, 4'd3, 36'h0, 1'b1);
        step();
        check("R6 sleeping write ignored", rdata, E3);

        drive(1'b1, 1'b1, 4'hF, 4'd0, 36'h0, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule